// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Target

This block stands in for the digital side of a sigma-delta converter on an SPI bus. A controller under test talks to it exactly as it would to the real converter. It sends a command byte, then moves data to or from one of eight registers, and then the port waits for the next command byte. Conversion results do not come from any analog circuit. They come from a test input port and appear after a delay. That delay is a number of system clocks scaled by the rate field of the mode register.

The serial port works in SPI mode 3. The target samples the data-in line on rising serial-clock edges and changes its data-out line on falling edges. All three SPI inputs are oversampled by the system clock. When chip select is low and no read is in progress, the data-out line carries an active-low ready flag, which lets the controller wait for a result by polling the line. A run of 48 consecutive one bits resets the serial port and all registers.

Top module: `sdt_spi_target`

## Requirements
- R1: After reset the registers read mode 0x400060, configuration 0x000110, GPO 0x00, offset 0x800000 and full-scale 0x5A0000. The ID register reads the constant 0xA4, and its low nibble 0x4 names the variant.
- R2: A command byte is taken MSB first. Bit 7 must be 0, bit 6 set means read and clear means write, and bits 5:3 give the register address. A byte with bit 7 set is ignored, and the next byte is again a command. After every completed access the port waits for a command.
- R3: Addresses 1 (mode), 2 (configuration), 6 (offset) and 7 (full-scale) hold 24 bits, and address 5 (GPO) holds 8 bits. Each is written and read back MSB first with the value written. Status (0) and ID (4) are 8 bits wide and data (3) is 24 bits wide.
- R4: A write command to address 0, 3 or 4 has no data phase. The byte after it is decoded as a command.
- R5: The status byte reads {not-ready, error, reference-missing, 0, 0, channel[2:0]}. The channel is the index of the lowest set bit in configuration bits 15:8. The error bit is taken from the error input when a conversion completes, and the reference-missing bit follows its input.
- R6: Writing mode select 1 (bits 23:21) starts one conversion. The conversion completes rate × 2 system clocks later, where rate is mode bits 9:0 and a rate of 0 counts as 1. On completion the result input is latched into the data register, ready is set, and mode select becomes 2 (idle). Selects 2 and 3 start no conversion.
- R7: Mode select 0 repeats conversions back to back. Each completion latches the current result input.
- R8: Mode selects 4 and 6 latch the result input into the offset register, and 5 and 7 latch it into the full-scale register. In each case mode select then becomes 2 and ready is set.
- R9: With chip select high, data-out is 1. With chip select low and no read in progress, data-out is 0 exactly when a result is ready.
- R10: Ready clears once the data register has been read in full, or when the mode register is written.
- R11: Forty-eight consecutive ones sampled on the data-in line reset every register to its R1 value. Forty ones followed by a zero change nothing.
- R12: Raising chip select mid-byte discards the partial byte, and the next byte after chip select falls is a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the target |
| spi_miso | output | 1 | Serial data out, doubling as active-low ready |
| conv_data_i | input | 24 | Result the next conversion will deliver |
| conv_err_i | input | 1 | Range error to report with the next result |
| ref_missing_i | input | 1 | Live reference-missing flag for status |

## Verification
A wrong command-decode state shows up within one byte. The byte after a bad decode is taken as data or as a command when it should be the other, so the next read-back returns a foreign value. A wrong conversion or ready state shows on the data-out line while chip select is low, one delay period after the mode write. A mode select that fails to fall back to idle is exposed by the next mode read. A ones counter that does not clear on a zero destroys register contents that a later read expects to survive.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
   localparam int REG_W  = 24;
   localparam int BYTE_W = 8;
   localparam int SEL_W  = 3;

   localparam logic [2:0] ADR_STAT = 3'd0;
   localparam logic [2:0] ADR_MODE = 3'd1;
   localparam logic [2:0] ADR_CONF = 3'd2;
   localparam logic [2:0] ADR_DATA = 3'd3;
   localparam logic [2:0] ADR_ID   = 3'd4;
   localparam logic [2:0] ADR_GPO  = 3'd5;
   localparam logic [2:0] ADR_OFFS = 3'd6;
   localparam logic [2:0] ADR_FS   = 3'd7;

   localparam logic [2:0] SEL_CONT   = 3'd0;
   localparam logic [2:0] SEL_SINGLE = 3'd1;
   localparam logic [2:0] SEL_IDLE   = 3'd2;
   localparam logic [2:0] SEL_PDOWN  = 3'd3;

   typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_t;

   function automatic logic is_narrow(input logic [2:0] a);
      return (a == ADR_STAT) || (a == ADR_ID) || (a == ADR_GPO);
   endfunction

   function automatic logic is_writable(input logic [2:0] a);
      return (a == ADR_MODE) || (a == ADR_CONF) || (a == ADR_GPO) ||
             (a == ADR_OFFS) || (a == ADR_FS);
   endfunction

   function automatic logic sel_runs(input logic [2:0] s);
      return (s != SEL_IDLE) && (s != SEL_PDOWN);
   endfunction

   function automatic logic sel_is_cal(input logic [2:0] s);
      return s[2];
   endfunction
endpackage

// File: rtl/sdt_sync_edge.sv
module sdt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic mosi_s
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] sclk_p;
   logic [LAST:0] cs_p;
   logic [LAST:0] mosi_p;
   logic          sclk_prev;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sclk_p[g] <= 1'b1;
                  cs_p[g]   <= 1'b1;
                  mosi_p[g] <= 1'b0;
               end else begin
                  sclk_p[g] <= sclk_i;
                  cs_p[g]   <= cs_n_i;
                  mosi_p[g] <= mosi_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sclk_p[g] <= 1'b1;
                  cs_p[g]   <= 1'b1;
                  mosi_p[g] <= 1'b0;
               end else begin
                  sclk_p[g] <= sclk_p[g-1];
                  cs_p[g]   <= cs_p[g-1];
                  mosi_p[g] <= mosi_p[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b1;
      else        sclk_prev <= sclk_p[LAST];
   end

   assign sclk_rise = sclk_p[LAST] & ~sclk_prev;
   assign sclk_fall = ~sclk_p[LAST] & sclk_prev;
   assign cs_act    = ~cs_p[LAST];
   assign mosi_s    = mosi_p[LAST];
endmodule

// File: rtl/sdt_serial.sv
module sdt_serial
   import sdt_pkg::*;
#(
   parameter int ONES_RST = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             fall,
   input  logic             cs_act,
   input  logic             mosi,
   input  logic [REG_W-1:0] rd_word,
   output logic [2:0]       cmd_addr,
   output logic             wr_stb,
   output logic [2:0]       acc_addr,
   output logic [REG_W-1:0] wr_data,
   output logic             rd_done,
   output logic             rd_phase,
   output logic             ph_cmd,
   output logic             out_bit,
   output logic             soft_rst
);
   localparam int CNT_W  = $clog2(REG_W + 1);
   localparam int ONES_W = $clog2(ONES_RST + 1);
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

   phase_t             phase_q;
   logic [CNT_W-1:0]   bitcnt_q;
   logic [CNT_W-1:0]   nbits_q;
   logic [REG_W-2:0]   sh_in;
   logic [REG_W-1:0]   sh_out;
   logic [REG_W-1:0]   word_next;
   logic [ONES_W-1:0]  ones_q;
   logic               last_bit;

   assign word_next = {sh_in, mosi};
   assign cmd_addr  = word_next[5:3];
   assign last_bit  = (bitcnt_q == nbits_q - CNT_W'(1));
   assign rd_phase  = (phase_q == PH_RD);
   assign ph_cmd    = (phase_q == PH_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q   <= '0;
         soft_rst <= 1'b0;
      end else begin
         soft_rst <= 1'b0;
         if (rise && cs_act) begin
            if (!mosi) begin
               ones_q <= '0;
            end else if (ones_q == ONES_W'(ONES_RST - 1)) begin
               ones_q   <= '0;
               soft_rst <= 1'b1;
            end else begin
               ones_q <= ones_q + ONES_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_CMD;
         bitcnt_q <= '0;
         nbits_q  <= CNT_W'(BYTE_W);
         acc_addr <= '0;
         sh_in    <= '0;
         sh_out   <= '0;
         out_bit  <= 1'b1;
         wr_stb   <= 1'b0;
         wr_data  <= '0;
         rd_done  <= 1'b0;
      end else begin
         wr_stb  <= 1'b0;
         rd_done <= 1'b0;
         if (soft_rst || !cs_act) begin
            phase_q  <= PH_CMD;
            bitcnt_q <= '0;
            out_bit  <= 1'b1;
         end else begin
            if (fall && phase_q == PH_RD) begin
               out_bit <= sh_out[REG_W-1];
               sh_out  <= {sh_out[REG_W-2:0], 1'b0};
            end
            if (rise) begin
               sh_in    <= word_next[REG_W-2:0];
               bitcnt_q <= bitcnt_q + CNT_W'(1);
               unique case (phase_q)
                  PH_CMD: begin
                     if (bitcnt_q == BYTE_LAST) begin
                        bitcnt_q <= '0;
                        if (!word_next[7]) begin
                           acc_addr <= cmd_addr;
                           nbits_q  <= is_narrow(cmd_addr) ? CNT_W'(BYTE_W) : CNT_W'(REG_W);
                           if (word_next[6]) begin
                              phase_q <= PH_RD;
                              sh_out  <= is_narrow(cmd_addr) ?
                                         {rd_word[BYTE_W-1:0], {(REG_W-BYTE_W){1'b0}}} : rd_word;
                           end else if (is_writable(cmd_addr)) begin
                              phase_q <= PH_WR;
                           end
                        end
                     end
                  end
                  PH_WR: begin
                     if (last_bit) begin
                        bitcnt_q <= '0;
                        phase_q  <= PH_CMD;
                        wr_stb   <= 1'b1;
                        wr_data  <= (nbits_q == CNT_W'(BYTE_W)) ?
                                    {{(REG_W-BYTE_W){1'b0}}, word_next[BYTE_W-1:0]} : word_next;
                     end
                  end
                  PH_RD: begin
                     if (last_bit) begin
                        bitcnt_q <= '0;
                        phase_q  <= PH_CMD;
                        rd_done  <= 1'b1;
                     end
                  end
                  default: phase_q <= PH_CMD;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/sdt_conv_timer.sv
module sdt_conv_timer #(
   parameter int RATE_W       = 10,
   parameter int CLK_PER_RATE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic [RATE_W-1:0] rate,
   output logic              done,
   output logic              busy
);
   localparam int CNT_W = RATE_W + $clog2(CLK_PER_RATE + 1) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rate_eff;
   logic [CNT_W-1:0] load_val;

   assign rate_eff = (rate == '0) ? CNT_W'(1) : CNT_W'(rate);
   assign load_val = rate_eff * CNT_W'(CLK_PER_RATE) - CNT_W'(1);
   assign done     = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= load_val;
      end else if (stop) begin
         busy  <= 1'b0;
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/sdt_spi_target.sv
module sdt_spi_target
   import sdt_pkg::*;
#(
   parameter int              SYNC_STAGES  = 2,
   parameter int              RATE_W       = 10,
   parameter int              CLK_PER_RATE = 2,
   parameter int              CHAN_N       = 8,
   parameter int              ONES_RST     = 48,
   parameter logic [7:0]      ID_VALUE     = 8'hA4,
   parameter logic [23:0]     MODE_RST     = 24'h400060,
   parameter logic [23:0]     CONF_RST     = 24'h000110,
   parameter logic [23:0]     OFFS_RST     = 24'h800000,
   parameter logic [23:0]     FS_RST       = 24'h5A0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sclk,
   input  logic        spi_cs_n,
   input  logic        spi_mosi,
   output logic        spi_miso,
   input  logic [23:0] conv_data_i,
   input  logic        conv_err_i,
   input  logic        ref_missing_i
);
   localparam int SEL_LSB  = REG_W - SEL_W;
   localparam int CHAN_LSB = 8;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("sync chain needs two stages");
      assert (RATE_W >= 1 && RATE_W <= SEL_LSB) else $error("rate field overlaps select");
      assert (CHAN_N >= 1 && CHAN_N <= 8) else $error("channel field is one byte");
      assert (CLK_PER_RATE >= 1) else $error("delay scale must be positive");
      assert (ONES_RST >= 16) else $error("reset run too short");
   end

   logic             rise, fall, cs_act, mosi_s;
   logic [2:0]       cmd_addr, acc_addr;
   logic             wr_stb, rd_done, rd_phase, ph_cmd, out_bit, soft_rst;
   logic [REG_W-1:0] wr_data, rd_word;
   logic             conv_done, conv_busy, tmr_start, tmr_stop;
   logic [RATE_W-1:0] tmr_rate;

   logic [REG_W-1:0] mode_q, conf_q, offs_q, fs_q, data_q;
   logic [7:0]       gpo_q;
   logic             err_q, rdy_q;
   logic [2:0]       chan_code;
   logic [7:0]       status8;
   logic             wr_mode;
   logic [2:0]       sel_q, sel_new;

   sdt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
      .sclk_rise(rise), .sclk_fall(fall), .cs_act(cs_act), .mosi_s(mosi_s)
   );

   sdt_serial #(.ONES_RST(ONES_RST)) u_serial (
      .clk(clk), .rst_n(rst_n),
      .rise(rise), .fall(fall), .cs_act(cs_act), .mosi(mosi_s),
      .rd_word(rd_word), .cmd_addr(cmd_addr),
      .wr_stb(wr_stb), .acc_addr(acc_addr), .wr_data(wr_data),
      .rd_done(rd_done), .rd_phase(rd_phase), .ph_cmd(ph_cmd),
      .out_bit(out_bit), .soft_rst(soft_rst)
   );

   sdt_conv_timer #(.RATE_W(RATE_W), .CLK_PER_RATE(CLK_PER_RATE)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(tmr_start), .stop(tmr_stop), .rate(tmr_rate),
      .done(conv_done), .busy(conv_busy)
   );

   assign sel_q    = mode_q[SEL_LSB +: SEL_W];
   assign sel_new  = wr_data[SEL_LSB +: SEL_W];
   assign wr_mode  = wr_stb && (acc_addr == ADR_MODE);
   assign tmr_rate = wr_mode ? wr_data[RATE_W-1:0] : mode_q[RATE_W-1:0];
   assign tmr_start = !soft_rst &&
                      ((wr_mode && sel_runs(sel_new)) ||
                       (!wr_mode && conv_done && sel_q == SEL_CONT));
   assign tmr_stop  = soft_rst || (wr_mode && !sel_runs(sel_new));

   // lowest set channel bit wins
   always_comb begin
      chan_code = '0;
      for (int i = CHAN_N - 1; i >= 0; i--) begin
         if (conf_q[CHAN_LSB + i]) chan_code = 3'(i);
      end
   end

   assign status8 = {~rdy_q, err_q, ref_missing_i, 2'b00, chan_code};

   always_comb begin
      unique case (cmd_addr)
         ADR_STAT: rd_word = {{(REG_W-8){1'b0}}, status8};
         ADR_MODE: rd_word = mode_q;
         ADR_CONF: rd_word = conf_q;
         ADR_DATA: rd_word = data_q;
         ADR_ID:   rd_word = {{(REG_W-8){1'b0}}, ID_VALUE};
         ADR_GPO:  rd_word = {{(REG_W-8){1'b0}}, gpo_q};
         ADR_OFFS: rd_word = offs_q;
         default:  rd_word = fs_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         conf_q <= CONF_RST;
         offs_q <= OFFS_RST;
         fs_q   <= FS_RST;
         gpo_q  <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
         rdy_q  <= 1'b0;
      end else if (soft_rst) begin
         mode_q <= MODE_RST;
         conf_q <= CONF_RST;
         offs_q <= OFFS_RST;
         fs_q   <= FS_RST;
         gpo_q  <= '0;
         data_q <= '0;
         err_q  <= 1'b0;
         rdy_q  <= 1'b0;
      end else begin
         if (conv_done) begin
            rdy_q <= 1'b1;
            if (sel_is_cal(sel_q)) begin
               if (sel_q[0]) fs_q   <= conv_data_i;
               else          offs_q <= conv_data_i;
            end else begin
               data_q <= conv_data_i;
               err_q  <= conv_err_i;
            end
            if (sel_q != SEL_CONT) mode_q[SEL_LSB +: SEL_W] <= SEL_IDLE;
         end else if (rd_done && acc_addr == ADR_DATA) begin
            rdy_q <= 1'b0;
         end
         if (wr_stb) begin
            unique case (acc_addr)
               ADR_MODE: begin
                  mode_q <= wr_data;
                  rdy_q  <= 1'b0;
               end
               ADR_CONF: conf_q <= wr_data;
               ADR_GPO:  gpo_q  <= wr_data[7:0];
               ADR_OFFS: offs_q <= wr_data;
               ADR_FS:   fs_q   <= wr_data;
               default:  ;
            endcase
         end
      end
   end

   assign spi_miso = !cs_act ? 1'b1 : (rd_phase ? out_bit : ~rdy_q);
endmodule

// File: rtl/sdt_spi_target_chk.sv
module sdt_spi_target_chk #(
   parameter int          SYNC_STAGES = 2,
   parameter logic [23:0] MODE_RST    = 24'h400060,
   parameter logic [23:0] CONF_RST    = 24'h000110
) (
   input logic        clk,
   input logic        rst_n,
   input logic        spi_cs_n,
   input logic        spi_miso,
   input logic        conv_done,
   input logic        wr_mode,
   input logic        soft_rst,
   input logic        rdy_q,
   input logic [23:0] mode_q,
   input logic [23:0] conf_q,
   input logic        ph_cmd
);
   localparam int HI_W = 4;
   localparam logic [HI_W-1:0] HI_LIM = HI_W'(SYNC_STAGES + 2);

   logic [HI_W-1:0] cs_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cs_hi_cnt <= '0;
      else if (!spi_cs_n)    cs_hi_cnt <= '0;
      else if (cs_hi_cnt != HI_LIM) cs_hi_cnt <= cs_hi_cnt + HI_W'(1);
   end

   AST_MISO_HIGH_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hi_cnt == HI_LIM) |-> spi_miso) else $error("miso low while deselected"); // R9

   AST_DESELECT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hi_cnt == HI_LIM) |-> ph_cmd) else $error("transfer not aborted"); // R12

   AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !wr_mode && !soft_rst) |=> rdy_q) else $error("ready not set"); // R6

   AST_SINGLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !wr_mode && !soft_rst && mode_q[23:21] == 3'd1) |=> (mode_q[23:21] == 3'd2))
      else $error("single did not return to idle"); // R6

   AST_CAL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !wr_mode && !soft_rst && mode_q[23]) |=> (mode_q[23:21] == 3'd2))
      else $error("calibration did not return to idle"); // R8

   AST_ONES_RESET_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (conf_q == CONF_RST && mode_q == MODE_RST && !rdy_q))
      else $error("ones run did not reset"); // R11
endmodule

bind sdt_spi_target sdt_spi_target_chk #(
   .SYNC_STAGES(SYNC_STAGES), .MODE_RST(MODE_RST), .CONF_RST(CONF_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
   .conv_done(conv_done), .wr_mode(wr_mode), .soft_rst(soft_rst),
   .rdy_q(rdy_q), .mode_q(mode_q), .conf_q(conf_q), .ph_cmd(ph_cmd)
);

// File: tb/tb_sdt_spi_target.sv
module tb_sdt_spi_target;
   localparam int H = 8;
   localparam logic [23:0] MODE_RST = 24'h400060;
   localparam logic [23:0] CONF_RST = 24'h000110;
   localparam logic [23:0] OFFS_RST = 24'h800000;
   localparam logic [23:0] FS_RST   = 24'h5A0000;
   localparam logic [7:0]  ID_VAL   = 8'hA4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
   logic miso;
   logic [23:0] conv_data = '0;
   logic conv_err = 1'b0, ref_miss = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [23:0] model [8];

   always #5 clk = ~clk;

   sdt_spi_target dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .conv_data_i(conv_data),
      .conv_err_i(conv_err), .ref_missing_i(ref_miss)
   );

   function automatic logic [23:0] mk_mode(input logic [2:0] sel, input logic [9:0] rate);
      return {sel, 11'd0, rate};
   endfunction

   function automatic bit narrow(input logic [2:0] a);
      return (a == 3'd0) || (a == 3'd4) || (a == 3'd5);
   endfunction

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         sclk = 1'b0;
         mosi = tx[i];
         wait_clk(H);
         rx[i] = miso;
         sclk = 1'b1;
         wait_clk(H);
      end
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] d;
      xfer(tx, d);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [23:0] v);
      send({2'b00, a, 3'b000});
      if (narrow(a)) send(v[7:0]);
      else begin
         send(v[23:16]); send(v[15:8]); send(v[7:0]);
      end
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
      logic [7:0] b;
      send({2'b01, a, 3'b000});
      v = '0;
      for (int k = 0; k < (narrow(a) ? 1 : 3); k++) begin
         xfer(8'h00, b);
         v = {v[15:0], b};
      end
   endtask

   task automatic reset_model();
      model[0] = '0; model[1] = MODE_RST; model[2] = CONF_RST; model[3] = '0;
      model[4] = {16'd0, ID_VAL}; model[5] = '0; model[6] = OFFS_RST; model[7] = FS_RST;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [23:0] v;
      logic [2:0]  a;
      logic [31:0] r;
      void'($urandom(32'd20240611));
      reset_model();
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(5);

      // R9: deselected line high, selected and not ready also high
      chk("R9 deselected", {23'd0, miso}, 24'd1);
      cs_n = 1'b0;
      wait_clk(8);
      chk("R9 not ready", {23'd0, miso}, 24'd1);

      // R1: reset values and ID
      rd_reg(3'd1, v); chk("R1 mode", v, MODE_RST);
      rd_reg(3'd2, v); chk("R1 conf", v, CONF_RST);
      rd_reg(3'd5, v); chk("R1 gpo", v, 24'd0);
      rd_reg(3'd6, v); chk("R1 offset", v, OFFS_RST);
      rd_reg(3'd7, v); chk("R1 fullscale", v, FS_RST);
      rd_reg(3'd4, v); chk("R1 id", v, {16'd0, ID_VAL});
      chk("R1 id variant", {20'd0, v[3:0]}, 24'h4);

      // R3: random writes and reads against model
      for (int it = 0; it < 24; it++) begin
         r = $urandom;
         case (r[2:0] % 5)
            0: a = 3'd1;
            1: a = 3'd2;
            2: a = 3'd5;
            3: a = 3'd6;
            default: a = 3'd7;
         endcase
         v = $urandom;
         if (a == 3'd5) v = {16'd0, v[7:0]};
         if (a == 3'd1) v = {2'b01, v[21:0]};
         wr_reg(a, v);
         model[a] = v;
         rd_reg(a, v);
         chk("R3 readback", v, model[a]);
         a = r[10:8];
         if (a != 3'd0 && a != 3'd3) begin
            rd_reg(a, v);
            chk("R3 other reg", v, model[a]);
         end
      end

      // R2: byte with bit 7 set ignored, next byte is a command
      send(8'h90);
      rd_reg(3'd2, v); chk("R2 ignored byte", v, model[2]);
      // R4: writes to read-only addresses take no data
      send(8'h18);
      send(8'h20);
      send(8'h00);
      rd_reg(3'd2, v); chk("R4 no data phase", v, model[2]);

      // R12: partial byte aborted by chip select
      for (int i = 7; i >= 4; i--) begin
         @(negedge clk); sclk = 1'b0; mosi = (i == 4); wait_clk(H);
         sclk = 1'b1; wait_clk(H);
      end
      cs_n = 1'b1; wait_clk(10); cs_n = 1'b0; wait_clk(6);
      rd_reg(3'd2, v); chk("R12 abort", v, model[2]);

      // R6 / R5: single conversion
      wr_reg(3'd2, 24'h00A000);
      model[2] = 24'h00A000;
      conv_data = 24'hABCDEF; conv_err = 1'b1; ref_miss = 1'b1;
      wr_reg(3'd1, mk_mode(3'd1, 10'd50));
      wait_clk(40);
      chk("R6 not yet ready", {23'd0, miso}, 24'd1);
      wait_clk(80);
      chk("R6 ready after delay", {23'd0, miso}, 24'd0);
      cs_n = 1'b1; wait_clk(8);
      chk("R9 deselected while ready", {23'd0, miso}, 24'd1);
      cs_n = 1'b0; wait_clk(8);
      chk("R9 ready low", {23'd0, miso}, 24'd0);
      rd_reg(3'd0, v); chk("R5 status", v, 24'h000065);
      rd_reg(3'd1, v); chk("R6 back to idle", v, mk_mode(3'd2, 10'd50));
      rd_reg(3'd3, v); chk("R6 data", v, 24'hABCDEF);
      wait_clk(4);
      chk("R10 cleared by data read", {23'd0, miso}, 24'd1);

      // R10: mode write clears ready
      conv_err = 1'b0; ref_miss = 1'b0;
      wr_reg(3'd1, mk_mode(3'd1, 10'd5));
      wait_clk(40);
      chk("R10 ready set", {23'd0, miso}, 24'd0);
      wr_reg(3'd1, mk_mode(3'd2, 10'd5));
      wait_clk(8);
      chk("R10 cleared by mode write", {23'd0, miso}, 24'd1);
      rd_reg(3'd0, v); chk("R5 status no error", v, 24'h000085);

      // R7: continuous
      conv_data = 24'h111111;
      wr_reg(3'd1, mk_mode(3'd0, 10'd10));
      wait_clk(60);
      rd_reg(3'd3, v); chk("R7 first result", v, 24'h111111);
      conv_data = 24'h222222;
      wait_clk(60);
      rd_reg(3'd3, v); chk("R7 second result", v, 24'h222222);
      rd_reg(3'd1, v); chk("R7 stays continuous", v, mk_mode(3'd0, 10'd10));
      wr_reg(3'd1, mk_mode(3'd2, 10'd10));

      // R8: calibrations
      conv_data = 24'h0F0F0F;
      wr_reg(3'd1, mk_mode(3'd4, 10'd5));
      wait_clk(40);
      rd_reg(3'd6, v); chk("R8 zero cal offset", v, 24'h0F0F0F);
      rd_reg(3'd1, v); chk("R8 zero cal idle", v, mk_mode(3'd2, 10'd5));
      conv_data = 24'h707070;
      wr_reg(3'd1, mk_mode(3'd7, 10'd5));
      wait_clk(40);
      rd_reg(3'd7, v); chk("R8 full cal", v, 24'h707070);
      rd_reg(3'd6, v); chk("R8 offset kept", v, 24'h0F0F0F);

      // R11: 40 ones do nothing, 48 reset
      wr_reg(3'd2, 24'h123456);
      for (int k = 0; k < 5; k++) send(8'hFF);
      rd_reg(3'd2, v); chk("R11 forty ones", v, 24'h123456);
      send(8'h10);
      for (int k = 0; k < 6; k++) send(8'hFF);
      wait_clk(4);
      rd_reg(3'd2, v); chk("R11 conf reset", v, CONF_RST);
      rd_reg(3'd1, v); chk("R11 mode reset", v, MODE_RST);
      rd_reg(3'd6, v); chk("R11 offset reset", v, OFFS_RST);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule